// File: doc/BRIEF.md
# Multiplexer-array multiplier for GF(2^m) with an all-one modulus

This block multiplies two elements of the binary field GF(2^m) in polynomial (standard) basis. The modulus is f(x) = 1 + x + x^2 + ... + x^m, and it must be irreducible. Operand A is widened by one zero coefficient into the cyclic ring GF(2)[x]/(x^(m+1) + 1). In that ring, multiplying by a power of x is just a rotation of the wires.

Operand B is split into two-bit groups, with a zero pad bit added when m is odd. Each group steers a 4:1 multiplexer that chooses one of four values: zero, A, x·A or (1+x)·A. The chosen value is rotated into the group's position, and all rotated terms are XOR-summed. The (m+1)-bit sum is then folded back into m bits. This uses x^m = 1 + x + ... + x^(m-1): the top coefficient is XORed into every lower one.

The multiplier core is purely combinational and has no iteration. A parameter places an optional register on the product for test use. The register clears to zero on reset.

Top module: `gf2m_aop_mux_mul`

## Requirements
- R1: The width M is accepted only when M+1 is prime and 2 has multiplicative order M modulo M+1 (for example 4, 10, 12, 18, 28). Any other M stops elaboration. For an accepted M, the product of two nonzero operands is never zero.
- R2: With REG_OUT=1, `p` equals a·b mod f(x). Bit i of each bus is the coefficient of x^i, and the multiplication is polynomial multiplication over GF(2).
- R3: When either operand is zero, the product is zero.
- R4: When one operand is the element 1 (value 1), the product equals the other operand.
- R5: Multiplying by x (b = 2) shifts a up by one bit. If bit M-1 of a was set, the low M bits of the result are then inverted; this is the fold of x^M.
- R6: With REG_OUT=1, `p` presents the product of the operands sampled at the previous rising `clk` edge. While `rst_n` is low, `p` is held at zero; the reset is asynchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | M | Multiplicand, coefficient of x^i in bit i |
| b | input | M | Multiplier, consumed two bits per multiplexer |
| p | output | M | Product a·b mod (1 + x + ... + x^M) |

## Verification
Two things can occur in the same product. First, several bit pairs of b can select the (1+x)·A candidate, so their rotated terms overlap in one column of the XOR tree. Second, the extended top coefficient can end up set, so the fold inverts every lower bit. The exhaustive sweep at M=4 covers every combination of the two. At M=10, random vectors are added, together with directed cases such as x^(M-1)·x, which is built to produce only the fold.

Every result is compared with a bit-serial shift-and-add model that reduces by f(x) one step at a time. That model shares no structure with the multiplexer array.

// File: rtl/gf2m_aop_mux_mul.sv
module gf2m_aop_mux_mul #(
  parameter int M       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p
);
  localparam int N  = M + 1;
  localparam int NP = (M + 1) / 2;
  localparam int BW = 2 * NP;

  function automatic bit field_ok(input int m);
    int n, v;
    if (m < 2) return 1'b0;
    n = m + 1;
    for (int d = 2; d * d <= n; d++)
      if (n % d == 0) return 1'b0;
    v = 1;
    for (int k = 1; k <= m; k++) begin
      v = (v * 2) % n;
      if (v == 1 && k < m) return 1'b0;
    end
    return v == 1;
  endfunction

  function automatic logic [N-1:0] rotl(input logic [N-1:0] v, input int s);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[(i + s) % N] = v[i];
    return r;
  endfunction

  generate
    if (!field_ok(M)) begin : g_bad_m
      $error("M+1 must be prime with 2 primitive modulo M+1");
    end
  endgenerate

  logic [N-1:0]  ax, ax1, ax3;
  logic [BW-1:0] bp;
  logic [N-1:0]  term [NP];
  logic [N-1:0]  acc;
  logic [M-1:0]  prod;

  assign ax  = {1'b0, a};
  assign ax1 = rotl(ax, 1);
  assign ax3 = ax ^ ax1;
  assign bp  = BW'(b);

  generate
    for (genvar k = 0; k < NP; k++) begin : g_pair
      logic [N-1:0] pick;
      always_comb begin
        case (bp[2*k+1 -: 2])
          2'd0:    pick = '0;
          2'd1:    pick = ax;
          2'd2:    pick = ax1;
          default: pick = ax3;
        endcase
      end
      assign term[k] = rotl(pick, 2 * k);
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int k = 0; k < NP; k++) acc ^= term[k];
  end

  assign prod = acc[M-1:0] ^ {M{acc[M]}};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p <= '0;
        else        p <= prod;
      end

      function automatic logic [M-1:0] times_x(input logic [M-1:0] v);
        return v[M-1] ? ~{v[M-2:0], 1'b0} : {v[M-2:0], 1'b0};
      endfunction

      p_zero_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a == '0 || b == '0) |=> p == '0);
      p_unit_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b == M'(1)) |=> p == $past(a));
      p_unit_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a == M'(1)) |=> p == $past(b));
      p_times_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b == M'(2)) |=> p == times_x($past(a)));
      p_no_zero_div_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (a != '0 && b != '0) |=> p != '0);
    end else begin : g_comb
      assign p = prod;
    end
  endgenerate
endmodule

// File: tb/gf2m_aop_mux_mul_bench.sv
module gf2m_aop_mux_mul_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] a4 = '0, b4 = '0, p4;
  logic [9:0] a10 = '0, b10 = '0, p10;

  gf2m_aop_mux_mul #(.M(4), .REG_OUT(1'b1)) u_gf2m_aop_mux_mul (
    .clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .p(p4));
  gf2m_aop_mux_mul #(.M(10), .REG_OUT(1'b1)) u_gf2m_aop_mux_mul_m10 (
    .clk(clk), .rst_n(rst_n), .a(a10), .b(b10), .p(p10));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [3:0] q4[$];  string t4[$];
  logic [9:0] q10[$]; string t10[$];

  function automatic logic [15:0] ref_mul(input int m, input logic [15:0] x, input logic [15:0] y);
    logic [15:0] mask, r;
    mask = (16'h1 << m) - 16'h1;
    r = '0;
    for (int i = m - 1; i >= 0; i--) begin
      r = r[m-1] ? (((r << 1) & mask) ^ mask) : ((r << 1) & mask);
      if (y[i]) r ^= x;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive4(input logic [3:0] x, input logic [3:0] y, input string tag);
    logic [15:0] e;
    @(negedge clk);
    a4 = x; b4 = y;
    e = ref_mul(4, 16'(x), 16'(y));
    q4.push_back(e[3:0]); t4.push_back(tag);
  endtask

  task automatic drive10(input logic [9:0] x, input logic [9:0] y, input string tag);
    logic [15:0] e;
    @(negedge clk);
    a10 = x; b10 = y;
    e = ref_mul(10, 16'(x), 16'(y));
    q10.push_back(e[9:0]); t10.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q4.size() > 0)  check(t4.pop_front(),  16'(p4),  16'(q4.pop_front()));
    if (q10.size() > 0) check(t10.pop_front(), 16'(p10), 16'(q10.pop_front()));
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset m4", 16'(p4), 16'h0);
    check("R6 reset m10", 16'(p10), 16'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        drive4(4'(i), 4'(j),
               (i == 0 || j == 0) ? "R3 R2 m4" :
               (i == 1 || j == 1) ? "R4 R2 m4" :
               (j == 2) ? "R5 R2 m4" : "R1 R2 R6 m4");
    drive4(4'h8, 4'h2, "R5 fold m4");

    drive10(10'h0, 10'h2A7, "R3 m10");
    drive10(10'h155, 10'h0, "R3 m10");
    drive10(10'h001, 10'h31C, "R4 m10");
    drive10(10'h2E9, 10'h001, "R4 m10");
    drive10(10'h200, 10'h002, "R5 fold m10");
    drive10(10'h0F3, 10'h002, "R5 m10");
    drive10(10'h3FF, 10'h3FF, "R1 m10");
    drive10(10'h3FF, 10'h155, "R2 m10");
    for (int k = 0; k < 2000; k++)
      drive10(10'($urandom), 10'($urandom), "R1 R2 m10");

    repeat (3) @(negedge clk);
    a4 = 4'h7; b4 = 4'h9; a10 = 10'h123; b10 = 10'h321;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R6 async clear m4", 16'(p4), 16'h0);
    check("R6 async clear m10", 16'(p10), 16'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule